// File: doc/BRIEF.md
# Operand Read Crossbar with Late Bypass

This block sits in the issue stage of a pipelined integer core and picks the value of each source operand. Each read port can take its value from one of three places. The first is the data the register file returns for the requested index. The second is a result that an execution unit drives onto the result crossbar in the same cycle. The third is a small holding stage that remembers the results written back in the cycle before. The chosen value is registered, so operand selection takes a pipeline cycle of its own, and the execute stage sees the operand one cycle after the index was presented.

The holding stage covers a timing gap in the register file. A write lands at the end of the cycle in which the result is on the crossbar, but a read only returns the new value one cycle after that. Without the holding stage, an instruction issued exactly one cycle after its producer's write-back would read the stale value. With it, operands are correct for any issue gap: zero cycles (direct forward), one cycle (late bypass) and two or more cycles (the register file is current).

There is one holding slot per execution-unit lane. Each slot keeps the data and destination index that its lane wrote in the previous cycle, together with a valid flag.

Top module: `orx_operand_xbar`

## Requirements
- R1: While `rst_n` is low at a clock edge, every operand output becomes zero after that edge. Results that are on the crossbar during a reset cycle are not kept for a later bypass.
- R2: The operand outputs are registered. A change of the inputs shows on `op` only after the next rising clock edge, and not before it.
- R3: A result lane e forwards when bit e of `res_vld` is 1 and its index `res_idx[e]` equals a port's read index. The port then registers `res_data[e]` at that edge.
- R4: A result that lane e drove with its valid bit set in cycle t is used for a matching read index in cycle t+1, unless a crossbar result also matches in t+1.
- R5: When more than one source matches, the crossbar result of the current cycle wins over the held result, and the held result wins over the register-file data.
- R6: When neither a current nor a held result matches, the port registers its `rf_data` input. This includes a read two or more cycles after the last write to that index.
- R7: A lane whose valid bit is 0 is never forwarded and never held, whatever its index and data.
- R8: Each read port selects independently. Two ports may take different sources in the same cycle, or the same source.
- R9: A held result is valid for exactly one cycle. If its lane does not write in the next cycle, the slot no longer matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | NUM_RD*IDX_W (2x6) | Source register index per read port; element p belongs to port p |
| rf_data | input | NUM_RD*DATA_W (2x64) | Register-file read data per port, one cycle behind writes |
| res_vld | input | NUM_EU (3) | Bit e set: lane e drives a result this cycle |
| res_idx | input | NUM_EU*IDX_W (3x6) | Destination index per result lane |
| res_data | input | NUM_EU*DATA_W (3x64) | Result value per lane |
| op | output | NUM_RD*DATA_W (2x64) | Registered operand per read port |

## Verification
The assertions assume that no two valid lanes name the same destination in one cycle. This lets the lane selection be a plain AND-OR merge, and that assumption is itself checked as a property. The bench's vector table writes each index from at most one lane per cycle. Its register-file model delays every write by one extra cycle, so the stale window really exists at the ports. A directed case drives a deliberately wrong `rf_data` two cycles after a write. This shows that the holding slot has expired and that the register file, not the slot, supplies the value.

// File: rtl/orx_pkg.sv
// Package: shared types of the operand read crossbar.
// Assumes: nothing; holds only the operand source encoding.
package orx_pkg;

    // Which of the three places an operand came from.
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_XBAR = 2'd2
    } src_e;

endpackage

// File: rtl/orx_late_hold.sv
// Module: orx_late_hold
// Keeps, per result lane, the result written back in the previous cycle,
// so a read issued one cycle after write-back can still see it.
// Assumes: the register file needs one extra cycle after a write, so a
// held entry is only needed for a single cycle.
module orx_late_hold #(
    parameter int NUM_EU = 3,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_EU-1:0]              res_vld,
    input  logic [NUM_EU-1:0][IDX_W-1:0]   res_idx,
    input  logic [NUM_EU-1:0][DATA_W-1:0]  res_data,
    output logic [NUM_EU-1:0]              hold_vld,
    output logic [NUM_EU-1:0][IDX_W-1:0]   hold_idx,
    output logic [NUM_EU-1:0][DATA_W-1:0]  hold_data
);

    for (genvar e = 0; e < NUM_EU; e++) begin : g_lane
        // Capture this lane's write-back; drop the flag when the lane is idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_vld[e]  <= 1'b0;
                hold_idx[e]  <= '0;
                hold_data[e] <= '0;
            end else begin
                hold_vld[e] <= res_vld[e];
                if (res_vld[e]) begin
                    hold_idx[e]  <= res_idx[e];
                    hold_data[e] <= res_data[e];
                end
            end
        end

        // R4: a valid write-back is available in the following cycle.
        a_r4_hold_loads: assert property (@(posedge clk) disable iff (!rst_n)
            res_vld[e] |=> (hold_vld[e] && hold_idx[e] == $past(res_idx[e])
                            && hold_data[e] == $past(res_data[e])));

        // R9 and R7: an idle or invalid lane leaves nothing to bypass.
        a_r9_hold_expires: assert property (@(posedge clk) disable iff (!rst_n)
            !res_vld[e] |=> !hold_vld[e]);
    end

endmodule

// File: rtl/orx_port_sel.sv
// Module: orx_port_sel
// One read port: compares its index against current and held results,
// picks crossbar > held > register file, and registers the operand.
// Assumes: at most one lane matches among current results, and at most one
// among held results (distinct destinations per cycle).
module orx_port_sel
    import orx_pkg::*;
#(
    parameter int NUM_EU = 3,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [DATA_W-1:0]              rf_data,
    input  logic [NUM_EU-1:0]              res_vld,
    input  logic [NUM_EU-1:0][IDX_W-1:0]   res_idx,
    input  logic [NUM_EU-1:0][DATA_W-1:0]  res_data,
    input  logic [NUM_EU-1:0]              hold_vld,
    input  logic [NUM_EU-1:0][IDX_W-1:0]   hold_idx,
    input  logic [NUM_EU-1:0][DATA_W-1:0]  hold_data,
    output logic [DATA_W-1:0]              op_q
);

    logic [NUM_EU-1:0] xb_hit;
    logic [NUM_EU-1:0] hd_hit;
    logic [DATA_W-1:0] xb_val;
    logic [DATA_W-1:0] hd_val;
    src_e              src;
    logic [DATA_W-1:0] op_d;

    for (genvar e = 0; e < NUM_EU; e++) begin : g_cmp
        // Index compare against the lane's current and held result.
        assign xb_hit[e] = res_vld[e]  && (res_idx[e]  == rd_idx);
        assign hd_hit[e] = hold_vld[e] && (hold_idx[e] == rd_idx);
    end

    // AND-OR merge of the matching lanes; one-hot by the unique-destination rule.
    always_comb begin
        xb_val = '0;
        hd_val = '0;
        for (int e = 0; e < NUM_EU; e++) begin
            xb_val = xb_val | (res_data[e]  & {DATA_W{xb_hit[e]}});
            hd_val = hd_val | (hold_data[e] & {DATA_W{hd_hit[e]}});
        end
    end

    // Source priority: youngest value first.
    always_comb begin
        if (|xb_hit)      src = SRC_XBAR;
        else if (|hd_hit) src = SRC_HOLD;
        else              src = SRC_RF;
    end

    // Operand multiplexer driven by the chosen source.
    always_comb begin
        case (src)
            SRC_XBAR: op_d = xb_val;
            SRC_HOLD: op_d = hd_val;
            default:  op_d = rf_data;
        endcase
    end

    // Operand register: the crossbar's own pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= '0;
        else        op_q <= op_d;
    end

    // Assumption for R3: distinct valid destinations in one cycle.
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xb_hit));

    for (genvar e = 0; e < NUM_EU; e++) begin : g_chk
        // R3: a live match on lane e is what the port registers.
        a_r3_direct_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            xb_hit[e] |=> op_q == $past(res_data[e]));
        // R5: a held match only wins when no live result matches.
        a_r5_hold_second: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|xb_hit) && hd_hit[e]) |=> op_q == $past(hold_data[e]));
    end

    // R6: with no match the register file value passes through.
    a_r6_rf_default: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|xb_hit) && !(|hd_hit)) |=> op_q == $past(rf_data));

endmodule

// File: rtl/orx_operand_xbar.sv
// Module: orx_operand_xbar (top)
// Operand read crossbar: NUM_RD registered read ports, each choosing among
// live crossbar results, results held from the previous write-back, and
// register-file data.
// Assumes: the register file returns a written value two cycles after the
// result was on the crossbar; no two valid lanes share a destination.
module orx_operand_xbar #(
    parameter int NUM_RD = 2,
    parameter int NUM_EU = 3,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    input  logic [NUM_RD-1:0][DATA_W-1:0]  rf_data,
    input  logic [NUM_EU-1:0]              res_vld,
    input  logic [NUM_EU-1:0][IDX_W-1:0]   res_idx,
    input  logic [NUM_EU-1:0][DATA_W-1:0]  res_data,
    output logic [NUM_RD-1:0][DATA_W-1:0]  op
);

    logic [NUM_EU-1:0]             hold_vld;
    logic [NUM_EU-1:0][IDX_W-1:0]  hold_idx;
    logic [NUM_EU-1:0][DATA_W-1:0] hold_data;

    // One-cycle memory of written-back results, shared by all ports.
    orx_late_hold #(
        .NUM_EU (NUM_EU),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_vld   (res_vld),
        .res_idx   (res_idx),
        .res_data  (res_data),
        .hold_vld  (hold_vld),
        .hold_idx  (hold_idx),
        .hold_data (hold_data)
    );

    // One independent selector per read port (R8).
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        orx_port_sel #(
            .NUM_EU (NUM_EU),
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W)
        ) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (rd_idx[p]),
            .rf_data   (rf_data[p]),
            .res_vld   (res_vld),
            .res_idx   (res_idx),
            .res_data  (res_data),
            .hold_vld  (hold_vld),
            .hold_idx  (hold_idx),
            .hold_data (hold_data),
            .op_q      (op[p])
        );
    end

    // R1: reset leaves every operand at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> op == '0);

endmodule

// File: tb/sim_orx_operand_xbar.sv
module sim_orx_operand_xbar;

    localparam int NRD = 2;
    localparam int NEU = 3;
    localparam int IW  = 6;
    localparam int DW  = 64;
    localparam int NV  = 15;

    // Vector: {rd_a[32:27], rd_b[26:21], vld[20:18], idx2[17:12], idx1[11:6], idx0[5:0]}
    localparam logic [32:0] VEC [NV] = '{
        {6'd3,  6'd4,  3'b001, 6'd0,  6'd0,  6'd3 },  // gap 0 on r3
        {6'd3,  6'd3,  3'b000, 6'd0,  6'd0,  6'd0 },  // gap 1 on r3, both ports
        {6'd3,  6'd5,  3'b000, 6'd0,  6'd0,  6'd0 },  // gap 2 on r3
        {6'd7,  6'd9,  3'b110, 6'd9,  6'd7,  6'd0 },  // two lanes, two ports
        {6'd7,  6'd9,  3'b001, 6'd0,  6'd0,  6'd7 },  // R5: live r7 beats held r7
        {6'd7,  6'd9,  3'b000, 6'd0,  6'd0,  6'd0 },
        {6'd7,  6'd9,  3'b000, 6'd0,  6'd0,  6'd0 },
        {6'd1,  6'd2,  3'b001, 6'd0,  6'd0,  6'd12},  // no match on either port
        {6'd12, 6'd12, 3'b010, 6'd0,  6'd12, 6'd0 },  // R5: live lane1 beats held lane0
        {6'd12, 6'd0,  3'b000, 6'd0,  6'd0,  6'd0 },
        {6'd20, 6'd20, 3'b000, 6'd20, 6'd0,  6'd0 },  // R7: lane2 names r20, not valid
        {6'd20, 6'd21, 3'b000, 6'd0,  6'd0,  6'd0 },
        {6'd63, 6'd62, 3'b100, 6'd63, 6'd0,  6'd0 },  // top index
        {6'd63, 6'd63, 3'b000, 6'd0,  6'd0,  6'd0 },
        {6'd0,  6'd63, 3'b000, 6'd0,  6'd0,  6'd0 }
    };

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic [NRD-1:0][IW-1:0]     rd_idx = '0;
    logic [NRD-1:0][DW-1:0]     rf_data = '0;
    logic [NEU-1:0]             res_vld = '0;
    logic [NEU-1:0][IW-1:0]     res_idx = '0;
    logic [NEU-1:0][DW-1:0]     res_data = '0;
    logic [NRD-1:0][DW-1:0]     op;

    bit [DW-1:0] arch   [64];   // architectural value after every write
    bit [DW-1:0] rf_vis [64];   // what the register file returns (one cycle late)
    bit [NEU-1:0]         pend_vld;
    bit [NEU-1:0][IW-1:0] pend_idx;
    bit [NEU-1:0][DW-1:0] pend_data;
    bit [DW-1:0]          exp_op [NRD];
    string                exp_tag [NRD];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    orx_operand_xbar u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rf_data  (rf_data),
        .res_vld  (res_vld),
        .res_idx  (res_idx),
        .res_data (res_data),
        .op       (op)
    );

    function automatic bit [DW-1:0] val_of(int k, int e);
        return {8'(e + 1), 24'(k), 32'hC0DE_0000 + 32'(k)};
    endfunction

    task automatic chk(string req, bit [DW-1:0] got, bit [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Present one cycle of inputs and work out the expected operands.
    task automatic drive(logic [32:0] v, int k);
        rd_idx[0] = v[32:27];
        rd_idx[1] = v[26:21];
        res_vld   = v[20:18];
        res_idx[2] = v[17:12];
        res_idx[1] = v[11:6];
        res_idx[0] = v[5:0];
        for (int e = 0; e < NEU; e++) res_data[e] = val_of(k, e);
        for (int p = 0; p < NRD; p++) begin
            rf_data[p] = rf_vis[rd_idx[p]];
            exp_op[p]  = arch[rd_idx[p]];
            exp_tag[p] = "R6";
            for (int e = 0; e < NEU; e++)
                if (pend_vld[e] && pend_idx[e] == rd_idx[p]) exp_tag[p] = "R4";
            for (int e = 0; e < NEU; e++)
                if (res_vld[e] && res_idx[e] == rd_idx[p]) begin
                    exp_op[p]  = res_data[e];
                    exp_tag[p] = "R3";
                end
        end
    endtask

    // Clock edge, then update the bench's register-file model; back at negedge.
    task automatic tick();
        @(posedge clk);
        #1;
        for (int e = 0; e < NEU; e++)
            if (pend_vld[e]) rf_vis[pend_idx[e]] = pend_data[e];
        pend_vld  = res_vld;
        pend_idx  = res_idx;
        pend_data = res_data;
        for (int e = 0; e < NEU; e++)
            if (res_vld[e]) arch[res_idx[e]] = res_data[e];
        @(negedge clk);
    endtask

    task automatic idle();
        res_vld = '0;
        rd_idx  = '0;
        for (int p = 0; p < NRD; p++) rf_data[p] = rf_vis[0];
    endtask

    initial begin
        bit [DW-1:0] prev [NRD];
        for (int i = 0; i < 64; i++) begin
            arch[i]   = {32'h5EED_0000 + 32'(i), 32'(i * 3)};
            rf_vis[i] = arch[i];
        end
        pend_vld = '0;

        // R1: reset state.
        idle();
        repeat (3) tick();
        for (int p = 0; p < NRD; p++) chk("R1 reset op", op[p], '0);
        rst_n = 1'b1;
        tick();

        // Table walk: R3, R4, R5, R6, R7 and R8 by vector.
        for (int k = 0; k < NV; k++) begin
            for (int p = 0; p < NRD; p++) prev[p] = op[p];
            drive(VEC[k], k);
            #2;
            // R2: nothing moves before the edge.
            for (int p = 0; p < NRD; p++) chk("R2 before edge", op[p], prev[p]);
            tick();
            for (int p = 0; p < NRD; p++) chk(exp_tag[p], op[p], exp_op[p]);
        end
        idle();
        tick();

        // R9: two cycles after a write the register file supplies the value.
        drive({6'd0, 6'd0, 3'b010, 6'd0, 6'd40, 6'd0}, 100);
        tick();
        idle();
        tick();
        rd_idx[0]  = 6'd40;
        rf_data[0] = 64'hDEAD_BEEF_0BAD_F00D;
        tick();
        chk("R9 held entry expired", op[0], 64'hDEAD_BEEF_0BAD_F00D);

        // R1: a write seen during reset is not held for a bypass.
        drive({6'd0, 6'd0, 3'b001, 6'd0, 6'd0, 6'd5}, 200);
        rst_n = 1'b0;
        tick();
        chk("R1 op during reset", op[0], '0);
        rst_n = 1'b1;
        idle();
        rd_idx[0]  = 6'd5;
        rd_idx[1]  = 6'd5;
        rf_data[0] = rf_vis[5];
        rf_data[1] = rf_vis[5];
        prev[0]    = rf_vis[5];
        tick();
        chk("R1 no hold after reset", op[0], prev[0]);
        chk("R1 no hold after reset", op[1], prev[0]);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule